// File: doc/BRIEF.md
# Carry-Save Bit Serializer

This block takes a number held in redundant carry-save form and sends out its binary value one bit per clock cycle, least significant bit first. The operand comes in as two vectors, a partial-sum vector and a carry vector, each R+1 bits wide. Its value is the partial sum plus twice the carry. The block never resolves the full carry chain. Each cycle it passes its two state registers through one layer of half adders, emits the lowest working sum bit, and shifts both registers one position down.

A one-cycle load strobe captures a new operand. In the load cycle the serial output comes straight from bit 0 of the partial-sum input, with no register in the path. After that cycle the bits follow from the stored state. The load strobe may be raised again in any cycle, and the new operand then replaces the old one.

Top module: `csa_serializer`

## Requirements
- R1: A synchronous active-high reset clears the state. After reset, while load stays low, the serial output is 0 on every cycle.
- R2: In a cycle where load is high, the serial output equals bit 0 of the partial-sum input in that same cycle.
- R3: If load is high in cycle t and low in cycles t+1 through t+k, then in cycle t+k the serial output equals bit k of (partial-sum input + 2 × carry input), where both inputs are the values sampled at cycle t.
- R4: Every bit position above the top bit of that value reads as 0. For R+1-bit inputs the value fits in R+3 bits, so every cycle t+k with k ≥ R+3 gives 0 while load stays low.
- R5: Raising load in the middle of a sequence drops the old operand. The bits that follow depend only on the new operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Captures a new operand this cycle |
| sum_in | input | R+1 | Partial-sum vector of the operand |
| carry_in | input | R+1 | Carry vector of the operand, weighted by two |
| bit_out | output | 1 | Serial result bit |

## Verification
The bypass bit is due combinationally, in the load cycle itself. Bit k of the operand is due in the cycle k rising edges after the load edge, and the zero output after reset is due from the first edge with reset high. The bench changes inputs on the falling edge and samples the output 1 ns later, well before the next rising edge. Each sample therefore reads the output for the cycle whose index the bench counts from the load. Random operands with random run lengths exercise interrupted sequences and the high zero bits. Directed all-ones, all-zeros and carry-only operands cover the extremes.

// File: rtl/csa_serializer.sv
module csa_serializer #(
  parameter int R = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [R:0]   sum_in,
  input  logic [R:0]   carry_in,
  output logic         bit_out
);

  logic [R-1:0] s_q;
  logic [R:0]   c_q;
  logic [R:0]   ws;
  logic [R:0]   wc;

  assign ws = {c_q[R], s_q ^ c_q[R-1:0]};
  assign wc = {1'b0, s_q & c_q[R-1:0]};

  assign bit_out = load ? sum_in[0] : ws[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      s_q <= '0;
      c_q <= '0;
    end else if (load) begin
      s_q <= sum_in[R:1];
      c_q <= carry_in;
    end else begin
      s_q <= ws[R:1];
      c_q <= wc;
    end
  end

endmodule

// File: rtl/csa_serializer_chk.sv
module csa_serializer_chk #(
  parameter int R = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         load,
  input logic [R:0]   sum_in,
  input logic [R:0]   carry_in,
  input logic         bit_out,
  input logic [R-1:0] s_q,
  input logic [R:0]   c_q
);

  a_r1_idle_after_reset: assert property (@(posedge clk)
    rst |=> (load || !bit_out));

  a_r3_first_shift_bit: assert property (@(posedge clk) disable iff (rst)
    (load && carry_in == '0) |=> (load || bit_out == $past(sum_in[1])));

  a_r3_carry_top_clears: assert property (@(posedge clk) disable iff (rst)
    !load |=> (c_q[R] == 1'b0));

  a_r4_zero_stays_zero: assert property (@(posedge clk) disable iff (rst)
    (!load && s_q == '0 && c_q == '0) |=> (load || !bit_out));

  a_r5_reload_captures: assert property (@(posedge clk) disable iff (rst)
    load |=> (s_q == $past(sum_in[R:1]) && c_q == $past(carry_in)));

endmodule

bind csa_serializer csa_serializer_chk #(.R(R)) u_chk (
  .clk(clk), .rst(rst), .load(load), .sum_in(sum_in), .carry_in(carry_in),
  .bit_out(bit_out), .s_q(s_q), .c_q(c_q)
);

// File: tb/csa_serializer_tb.sv
module csa_serializer_tb;
  localparam int R = 8;
  localparam int W = R + 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load = 1'b0;
  logic [R:0]   sum_in = '0;
  logic [R:0]   carry_in = '0;
  logic         bit_out;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 1'b0;

  csa_serializer #(.R(R)) u_dut (
    .clk(clk), .rst(rst), .load(load), .sum_in(sum_in),
    .carry_in(carry_in), .bit_out(bit_out)
  );

  always #4 clk = ~clk;

  function automatic logic [63:0] ref_val(logic [R:0] s, logic [R:0] c);
    return 64'(s) + 2 * 64'(c);
  endfunction

  task automatic check(string tag, logic act, logic exp, int k);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s k=%0d actual=%0b expected=%0b", tag, k, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  // load at a falling edge, check bypass, then len unloaded cycles
  task automatic run_op(logic [R:0] s, logic [R:0] c, int len, string tag);
    logic [63:0] v;
    v = ref_val(s, c);
    @(negedge clk);
    load = 1'b1; sum_in = s; carry_in = c;
    #1 check("R2", bit_out, s[0], 0);
    for (int k = 1; k <= len; k++) begin
      @(negedge clk);
      load = 1'b0; sum_in = W'($urandom); carry_in = W'($urandom);
      #1 check((k >= R + 3) ? "R4" : tag, bit_out, v[k], k);
    end
  endtask

  initial begin
    int seed_init;
    seed_init = $urandom(32'd1187);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      #1 check("R1", bit_out, 1'b0, i);
    end

    run_op('1, '1, R + 6, "R3");
    run_op('0, '0, R + 4, "R3");
    run_op('0, '1, R + 5, "R3");
    run_op('1, '0, R + 5, "R3");
    run_op(W'(1), W'(1 << R), R + 5, "R3");

    run_op('1, '1, 2, "R3");
    run_op(W'(2), W'(0), R + 4, "R5");
    run_op(W'(9'h155), W'(9'h0AA), 1, "R3");
    run_op(W'(9'h0F0), W'(9'h10F), R + 4, "R5");

    for (int n = 0; n < 300; n++) begin
      int len;
      len = 1 + int'($urandom % (R + 6));
      run_op(W'($urandom), W'($urandom), len, (n % 2 == 0) ? "R3" : "R5");
    end

    @(negedge clk);
    load = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1 check("R1", bit_out, 1'b0, 0);

    done = 1'b1;
    report();
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
    end
  end

endmodule